// File: doc/BRIEF.md
# Prescaled Serial Bit-Rate Generator

This block derives the bit timing for a serial transmitter and receiver from the core clock. The core clock is first divided by four to form the bus clock. A non-power-of-two prescaler (1, 3, 4 or 13) and a power-of-two rate divider (2^0 to 2^7) then divide the bus clock to give a 16x oversampling tick. A sixteen-way divider on that tick gives one tick per serial bit. Both ticks are single-cycle pulses in the core clock domain.

Software programs the rate through one byte-wide rate register. A write strobe loads it and a read port returns it at all times. A write also restarts every divider stage, so the first tick after a rate change already has the new spacing. At reset the register is cleared, which gives the fastest rate. If the boot-mode input is high during reset, the register is loaded with 0x33 instead, which is a slow rate meant for a bootstrap loader. Two test bits and one spare bit in the register are stored but do nothing.

Top module: `baud_tick_gen`

## Requirements
- R1: With boot_mode_i low, reset clears the rate register, so rd_data_o reads 0x00.
- R2: With boot_mode_i high during reset, the rate register resets to 0x33, which is prescale 13 and rate field 3. The first bit tick then comes 6656 core cycles after reset release.
- R3: A cycle with wr_en_i high stores all eight bits of wr_data_i, and rd_data_o shows them from the next cycle. Without a write, rd_data_o holds its value.
- R4: Register bits [5:4] select the prescale factor: code 00 selects 1, 01 selects 3, 10 selects 4 and 11 selects 13.
- R5: Register bits [2:0] hold a rate field n. It multiplies the oversample period by 2^n.
- R6: os_tick_o is a one-cycle pulse. Its period is 4 x prescale x 2^n core cycles, because the bus clock is the core clock divided by 4.
- R7: bit_tick_o pulses on every sixteenth os_tick_o pulse, always in the same cycle as that pulse. Its period is 64 x prescale x 2^n core cycles.
- R8: A write restarts all dividers. The first os_tick_o pulse then appears 4 x prescale x 2^n - 1 cycles after the first cycle that follows the write, and the first bit_tick_o pulse appears 64 x prescale x 2^n - 1 cycles after it.
- R9: Register bits 7, 6 and 3 are stored and read back but have no effect on tick timing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| boot_mode_i | input | 1 | Selects the bootstrap reset value of the rate register |
| wr_en_i | input | 1 | Rate register write strobe |
| wr_data_i | input | 8 | Rate register write data |
| rd_data_o | output | 8 | Current rate register contents |
| os_tick_o | output | 1 | 16x oversampling tick |
| bit_tick_o | output | 1 | One tick per serial bit |

## Verification
The bench writes each of the 32 combinations of prescale code and rate field. For each one it measures the interval from the write to the first oversample tick. This separates a wrong prescale mapping, such as 13 swapped with 4, from a wrong shift amount, and it also shows whether the write restarts the counters. For the shorter rates, and for the bootstrap value, it also measures the full bit period, which checks the sixteen-way stage and its alignment with the oversample tick. Writes that differ only in the test and spare bits must give the same timing and read back intact. A cycle-level reference model checks both tick outputs on every clock.

// File: rtl/baud_tick_pkg.sv
`timescale 1ns/1ps
package baud_tick_pkg;
  localparam int unsigned RATE_W = 3;
  localparam int unsigned PRE_W  = 4;
  localparam int unsigned DIV_W  = PRE_W + (1 << RATE_W) - 1;

  typedef struct packed {
    logic              test_clr;
    logic              spare;
    logic [1:0]        pre_sel;
    logic              clk_chk;
    logic [RATE_W-1:0] rate_sel;
  } rate_reg_t;

  localparam logic [7:0] BOOT_VAL = 8'h33;

  function automatic logic [PRE_W-1:0] pre_factor(input logic [1:0] sel);
    case (sel)
      2'b00:   return PRE_W'(1);
      2'b01:   return PRE_W'(3);
      2'b10:   return PRE_W'(4);
      default: return PRE_W'(13);
    endcase
  endfunction
endpackage

// File: rtl/baud_bus_div.sv
`timescale 1ns/1ps
module baud_bus_div #(
  parameter int unsigned BUS_DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  output logic bus_en_o
);
  generate
    if (BUS_DIV <= 1) begin : g_pass
      assign bus_en_o = 1'b1;
    end else begin : g_cnt
      localparam int unsigned CW = $clog2(BUS_DIV);
      logic [CW-1:0] cnt_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                       cnt_q <= '0;
        else if (restart_i)                cnt_q <= '0;
        else if (cnt_q == CW'(BUS_DIV-1))  cnt_q <= '0;
        else                               cnt_q <= cnt_q + 1'b1;
      end
      assign bus_en_o = (cnt_q == CW'(BUS_DIV-1));
    end
  endgenerate
endmodule

// File: rtl/baud_os_div.sv
`timescale 1ns/1ps
module baud_os_div
  import baud_tick_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              restart_i,
  input  logic              bus_en_i,
  input  logic [1:0]        pre_sel_i,
  input  logic [RATE_W-1:0] rate_sel_i,
  output logic              os_tick_o
);
  logic [DIV_W-1:0] div_m1;
  logic [DIV_W-1:0] cnt_q;

  always_comb div_m1 = (DIV_W'(pre_factor(pre_sel_i)) << rate_sel_i) - 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (restart_i)   cnt_q <= '0;
    else if (bus_en_i)    cnt_q <= (cnt_q == div_m1) ? '0 : cnt_q + 1'b1;
  end

  assign os_tick_o = bus_en_i && (cnt_q == div_m1);
endmodule

// File: rtl/baud_bit_div.sv
`timescale 1ns/1ps
module baud_bit_div #(
  parameter int unsigned OS_RATE = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  input  logic os_tick_i,
  output logic bit_tick_o
);
  localparam int unsigned CW = (OS_RATE > 1) ? $clog2(OS_RATE) : 1;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         cnt_q <= '0;
    else if (restart_i)  cnt_q <= '0;
    else if (os_tick_i)  cnt_q <= (cnt_q == CW'(OS_RATE-1)) ? '0 : cnt_q + 1'b1;
  end

  assign bit_tick_o = os_tick_i && (cnt_q == CW'(OS_RATE-1));
endmodule

// File: rtl/baud_tick_gen.sv
`timescale 1ns/1ps
module baud_tick_gen
  import baud_tick_pkg::*;
#(
  parameter int unsigned BUS_DIV = 4,
  parameter int unsigned OS_RATE = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       boot_mode_i,
  input  logic       wr_en_i,
  input  logic [7:0] wr_data_i,
  output logic [7:0] rd_data_o,
  output logic       os_tick_o,
  output logic       bit_tick_o
);
  rate_reg_t rate_q;
  logic      bus_en;
  logic      os_tick;

  // Reset value depends on the boot strap sampled while reset is held.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       rate_q <= boot_mode_i ? rate_reg_t'(BOOT_VAL) : '0;
    else if (wr_en_i)  rate_q <= rate_reg_t'(wr_data_i);
  end

  assign rd_data_o = rate_q;

  baud_bus_div #(.BUS_DIV(BUS_DIV)) bus_div_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (wr_en_i),
    .bus_en_o  (bus_en)
  );

  baud_os_div os_div_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .restart_i  (wr_en_i),
    .bus_en_i   (bus_en),
    .pre_sel_i  (rate_q.pre_sel),
    .rate_sel_i (rate_q.rate_sel),
    .os_tick_o  (os_tick)
  );

  baud_bit_div #(.OS_RATE(OS_RATE)) bit_div_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .restart_i  (wr_en_i),
    .os_tick_i  (os_tick),
    .bit_tick_o (bit_tick_o)
  );

  assign os_tick_o = os_tick;
endmodule

// File: rtl/baud_tick_gen_chk.sv
`timescale 1ns/1ps
module baud_tick_gen_chk #(
  parameter int unsigned BUS_DIV = 4,
  parameter int unsigned OS_RATE = 16
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       wr_en_i,
  input logic [7:0] wr_data_i,
  input logic [7:0] rd_data_o,
  input logic       os_tick_o,
  input logic       bit_tick_o
);
  localparam int unsigned CW = (OS_RATE > 1) ? $clog2(OS_RATE) : 1;
  logic [CW-1:0] os_seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        os_seen_q <= '0;
    else if (wr_en_i)   os_seen_q <= '0;
    else if (os_tick_o) os_seen_q <= (os_seen_q == CW'(OS_RATE-1)) ? '0 : os_seen_q + 1'b1;
  end

  p_bit_on_os_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_tick_o |-> os_tick_o);

  p_bit_count_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    os_tick_o |-> (bit_tick_o == (os_seen_q == CW'(OS_RATE-1))));

  p_bit_gap_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_tick_o |=> !bit_tick_o);

  p_wr_store_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> (rd_data_o == $past(wr_data_i)));

  p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(rd_data_o));

  p_restart_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && (BUS_DIV > 1)) |=> !os_tick_o);
endmodule

bind baud_tick_gen baud_tick_gen_chk #(.BUS_DIV(BUS_DIV), .OS_RATE(OS_RATE)) chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wr_en_i    (wr_en_i),
  .wr_data_i  (wr_data_i),
  .rd_data_o  (rd_data_o),
  .os_tick_o  (os_tick_o),
  .bit_tick_o (bit_tick_o)
);

// File: tb/baud_tick_gen_tb_top.sv
`timescale 1ns/1ps
module baud_tick_gen_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       boot = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       os_tick, bit_tick;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  baud_tick_gen dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .boot_mode_i (boot),
    .wr_en_i     (wr_en),
    .wr_data_i   (wr_data),
    .rd_data_o   (rd_data),
    .os_tick_o   (os_tick),
    .bit_tick_o  (bit_tick)
  );

  // Behavioural reference: cycles since reset release or last write.
  int   m_cyc = 0;
  byte  m_reg = 8'h00;

  function automatic int fac(input int code);
    case (code)
      0: return 1;
      1: return 3;
      2: return 4;
      default: return 13;
    endcase
  endfunction

  function automatic int os_per(input logic [7:0] r);
    return 4 * fac(int'(r[5:4])) * (1 << r[2:0]);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cyc = 0;
      m_reg = boot ? 8'h33 : 8'h00;
    end else if (wr_en) begin
      m_cyc = 0;
      m_reg = wr_data;
    end else begin
      m_cyc = m_cyc + 1;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R6 os_tick", int'(os_tick), int'(((m_cyc + 1) % os_per(m_reg)) == 0));
      check("R7 bit_tick", int'(bit_tick), int'(((m_cyc + 1) % (16 * os_per(m_reg))) == 0));
    end
  end

  task automatic wr(input logic [7:0] v);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = v;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic meas_os(output int n);
    n = 0;
    while (!os_tick) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic meas_bit(output int n);
    n = 0;
    while (!bit_tick) begin
      @(negedge clk);
      n++;
    end
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int n;
    logic [7:0] v;
    repeat (3) @(negedge clk);
    check("R1 reset value", int'(rd_data), 0);
    rst_n = 1'b1;
    check("R1 reset value after release", int'(rd_data), 0);
    meas_os(n);
    check("R6 first os after reset", n, 3);

    // R4 R5 R8: every prescale/rate combination, first tick after write
    for (int p = 0; p < 4; p++) begin
      for (int r = 0; r < 8; r++) begin
        v = {2'b00, 2'(p), 1'b0, 3'(r)};
        wr(v);
        check("R3 readback", int'(rd_data), int'(v));
        meas_os(n);
        check("R4 R5 R8 os interval", n, os_per(v) - 1);
        if (r <= 2) begin
          wr(v);
          meas_bit(n);
          check("R7 R8 bit interval", n, 16 * os_per(v) - 1);
        end
      end
    end

    // R8: rewrite mid-period restarts the count
    wr(8'h12);
    repeat (20) @(negedge clk);
    wr(8'h12);
    meas_os(n);
    check("R8 restart mid-period", n, os_per(8'h12) - 1);

    // R9: test and spare bits have no timing effect
    wr(8'hC9);
    check("R9 readback", int'(rd_data), 8'hC9);
    meas_os(n);
    check("R9 os interval", n, os_per(8'h01) - 1);
    wr(8'hC9);
    meas_bit(n);
    check("R9 bit interval", n, 16 * os_per(8'h01) - 1);

    // R2: bootstrap reset value and its bit period
    @(negedge clk);
    boot = 1'b1;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check("R2 boot value in reset", int'(rd_data), 8'h33);
    rst_n = 1'b1;
    boot = 1'b0;
    meas_bit(n);
    check("R2 boot bit interval", n, 6655);
    check("R2 boot value held", int'(rd_data), 8'h33);

    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule